// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a stream of oscillator ticks (nominally 32,768 per second) into a one-cycle seconds strobe, and marks the last second of each minute. Calibration is digital. The block runs a repeating cycle of 64 minutes. In a number of minutes at the start of that cycle, it alters the length of the first second, and the number of minutes grows with the calibration magnitude. A positive setting speeds the clock up by cutting ticks from that second. A negative setting slows the clock by adding ticks. The tick chain is split into slices of 128 ticks, and every correction is a whole number of slices. The free-running low stage of the chain, which trim never touches, drives a test square wave at 1/64 of the tick rate (512 Hz nominal).

The calibration field is six bits wide. Bit 5 is the direction and bits 4..0 are the magnitude. The block latches the field at reset and again at every minute boundary, so a change made mid-minute never takes effect part way through a minute. A stop input freezes the whole chain, and counting resumes from the frozen state when stop is released.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With no trim in effect, consecutive pulses of `sec_stb` are exactly TICKS_PER_SEC advancing ticks apart. An advancing tick is a cycle with `osc_tick`=1 and `stop`=0. Each pulse lasts one cycle and appears in the cycle after the edge that takes in the final tick.
- R2: `min_stb` pulses in the same cycle as every SECS_PER_MIN-th `sec_stb` pulse and at no other time.
- R3: With magnitude N (`cal_in[4:0]`), only second 0 of minutes 0 to 2N−1 of the 64-minute cycle is altered. Every other second keeps the nominal length.
- R4: When `cal_in[5]`=1 (speed up), an altered second is SHORTEN_TICKS (256) ticks shorter than nominal.
- R5: When `cal_in[5]`=0 (slow down), an altered second is LENGTHEN_TICKS (128) ticks longer than nominal.
- R6: A magnitude of 0 leaves every second at nominal length for either direction bit.
- R7: The calibration field is sampled at reset and at each minute boundary. A change made inside a minute first affects the next minute.
- R8: `ftest_out` toggles after every TEST_DIV/2 advancing ticks, whatever the calibration value.
- R9: While `stop`=1, ticks are ignored: no `sec_stb` pulse occurs and `ftest_out` holds its level. Counting continues from the frozen state once `stop` is cleared.
- R10: Synchronous reset clears `sec_stb`, `min_stb` and `ftest_out` to 0. After reset the first minute is minute 0 of the 64-minute cycle, and its first second can already be trimmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator tick enable, one per oscillator cycle |
| stop | input | 1 | Freezes the divider while high |
| cal_in | input | 6 | Bit 5 = direction (1 speeds up), bits 4..0 = magnitude |
| sec_stb | output | 1 | One-cycle pulse per second |
| min_stb | output | 1 | One-cycle pulse with the last second of each minute |
| ftest_out | output | 1 | Trim-independent test square wave |

## Verification
Some properties are checked on every cycle:
- the minute marker never appears without a seconds strobe;
- each strobe lasts a single cycle;
- a stopped chain neither strobes nor moves the test wave;
- the latched calibration changes only at a minute boundary;
- the slice count never reaches the current target.

Other behaviour only the bench scenarios can show: the exact length of each second across a full 64-minute wrap, which minutes receive the correction, and the deferral of mid-minute calibration changes. The bench shows these under random tick gaps, stop bursts, calibration swaps and a reset in the middle of a run.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    typedef struct packed {
        logic       fast;   // 1: speed up (shorten), 0: slow down (lengthen)
        logic [4:0] mag;    // number of minute pairs to correct
    } trim_cfg_t;

    typedef enum logic [1:0] {
        KIND_NOMINAL = 2'd0,
        KIND_SHORT   = 2'd1,
        KIND_LONG    = 2'd2
    } sec_kind_e;

    // Decide how the second with index sec_i inside minute min_i is trimmed.
    function automatic sec_kind_e pick_kind(input int unsigned sec_i,
                                            input int unsigned min_i,
                                            input trim_cfg_t   cfg);
        if (sec_i != 0 || cfg.mag == 5'd0)
            return KIND_NOMINAL;
        if (min_i >= 2 * 32'(cfg.mag))
            return KIND_NOMINAL;
        return cfg.fast ? KIND_SHORT : KIND_LONG;
    endfunction

endpackage

// File: rtl/rtc_slice_prescaler.sv
module rtc_slice_prescaler #(
    parameter int unsigned SLICE_TICKS = 128,
    parameter int unsigned TEST_DIV    = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic slice_end,
    output logic ftest
);
    localparam int unsigned PW = $clog2(SLICE_TICKS);
    localparam int unsigned TW = $clog2(TEST_DIV);

    logic [PW-1:0] pre_q;

    assign slice_end = adv && (pre_q == PW'(SLICE_TICKS - 1));
    assign ftest     = pre_q[TW-1];

    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= '0;
        else if (adv)
            pre_q <= slice_end ? '0 : pre_q + PW'(1);
    end

    // R9
    ftest_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ftest));

endmodule

// File: rtl/rtc_second_divider.sv
module rtc_second_divider #(
    parameter int unsigned SW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slice_end,
    input  logic [SW-1:0] target,
    output logic          sec_end,
    output logic          sec_stb
);
    logic [SW-1:0] cnt_q;

    assign sec_end = slice_end && (cnt_q == target - SW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            sec_stb <= 1'b0;
        end else begin
            sec_stb <= sec_end;
            if (slice_end)
                cnt_q <= sec_end ? '0 : cnt_q + SW'(1);
        end
    end

    // R1
    slice_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < target);

    // R1
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        sec_stb |=> !sec_stb);

endmodule

// File: rtl/rtc_trim_scheduler.sv
module rtc_trim_scheduler
    import rtc_trim_pkg::*;
#(
    parameter int unsigned SECS     = 60,
    parameter int unsigned MINS     = 64,
    parameter int unsigned SLICES   = 256,
    parameter int unsigned SHORT_SL = 2,
    parameter int unsigned LONG_SL  = 1,
    parameter int unsigned SW       = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [5:0]    cal_in,
    input  logic          sec_end,
    output logic [SW-1:0] target,
    output logic          min_stb
);
    localparam int unsigned SECW = $clog2(SECS);
    localparam int unsigned MINW = $clog2(MINS);

    trim_cfg_t       cal_q;
    logic [SECW-1:0] sec_idx;
    logic [MINW-1:0] min_idx;
    logic            min_end;
    sec_kind_e       kind;

    assign min_end = sec_end && (sec_idx == SECW'(SECS - 1));
    assign kind    = pick_kind(32'(sec_idx), 32'(min_idx), cal_q);

    always_comb begin
        unique case (kind)
            KIND_SHORT: target = SW'(SLICES - SHORT_SL);
            KIND_LONG:  target = SW'(SLICES + LONG_SL);
            default:    target = SW'(SLICES);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q   <= trim_cfg_t'(cal_in);
            sec_idx <= '0;
            min_idx <= '0;
            min_stb <= 1'b0;
        end else begin
            min_stb <= min_end;
            if (min_end) begin
                cal_q   <= trim_cfg_t'(cal_in);
                sec_idx <= '0;
                min_idx <= (min_idx == MINW'(MINS - 1)) ? '0 : min_idx + MINW'(1);
            end else if (sec_end) begin
                sec_idx <= sec_idx + SECW'(1);
            end
        end
    end

    // R7
    cal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !min_end |=> $stable(cal_q));

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler #(
    parameter int unsigned TICKS_PER_SEC  = 32768,
    parameter int unsigned SLICE_TICKS    = 128,
    parameter int unsigned SECS_PER_MIN   = 60,
    parameter int unsigned MINS_PER_CYCLE = 64,
    parameter int unsigned SHORTEN_TICKS  = 256,
    parameter int unsigned LENGTHEN_TICKS = 128,
    parameter int unsigned TEST_DIV       = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       stop,
    input  logic [5:0] cal_in,
    output logic       sec_stb,
    output logic       min_stb,
    output logic       ftest_out
);
    localparam int unsigned SLICES   = TICKS_PER_SEC / SLICE_TICKS;
    localparam int unsigned SHORT_SL = SHORTEN_TICKS / SLICE_TICKS;
    localparam int unsigned LONG_SL  = LENGTHEN_TICKS / SLICE_TICKS;
    localparam int unsigned SW       = $clog2(SLICES + LONG_SL + 1);

    logic          adv;
    logic          slice_end;
    logic          sec_end;
    logic [SW-1:0] target;

    assign adv = osc_tick && !stop;

    rtc_slice_prescaler #(
        .SLICE_TICKS (SLICE_TICKS),
        .TEST_DIV    (TEST_DIV)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .slice_end (slice_end),
        .ftest     (ftest_out)
    );

    rtc_second_divider #(
        .SW (SW)
    ) u_sec (
        .clk       (clk),
        .rst       (rst),
        .slice_end (slice_end),
        .target    (target),
        .sec_end   (sec_end),
        .sec_stb   (sec_stb)
    );

    rtc_trim_scheduler #(
        .SECS     (SECS_PER_MIN),
        .MINS     (MINS_PER_CYCLE),
        .SLICES   (SLICES),
        .SHORT_SL (SHORT_SL),
        .LONG_SL  (LONG_SL),
        .SW       (SW)
    ) u_sched (
        .clk     (clk),
        .rst     (rst),
        .cal_in  (cal_in),
        .sec_end (sec_end),
        .target  (target),
        .min_stb (min_stb)
    );

    // R2
    min_with_sec_chk: assert property (@(posedge clk) disable iff (rst)
        min_stb |-> sec_stb);

    // R9
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !sec_stb);

endmodule

// File: tb/rtc_trim_prescaler_tb.sv
module rtc_trim_prescaler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS = 512;
    localparam int SLICE = 128;
    localparam int SECS  = 2;
    localparam int MINS  = 64;
    localparam int SHORT = 256;
    localparam int LONG  = 128;
    localparam int TDIV  = 64;
    localparam int NCYC  = 150000;
    localparam int RST2  = 100000;

    logic       clk = 1'b0;
    logic       rst, osc_tick, stop;
    logic [5:0] cal_in;
    logic       sec_stb, min_stb, ftest_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_trim_prescaler #(
        .TICKS_PER_SEC (TICKS), .SLICE_TICKS (SLICE), .SECS_PER_MIN (SECS),
        .MINS_PER_CYCLE(MINS),  .SHORTEN_TICKS(SHORT), .LENGTHEN_TICKS(LONG),
        .TEST_DIV      (TDIV)
    ) u_dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .stop(stop), .cal_in(cal_in),
        .sec_stb(sec_stb), .min_stb(min_stb), .ftest_out(ftest_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected length of a second from the requirements (R1, R3-R6).
    function automatic int exp_len(input int sec_i, input int min_i, input logic [5:0] cal);
        if (sec_i == 0 && cal[4:0] != 0 && min_i < 2 * int'(cal[4:0]))
            return cal[5] ? TICKS - SHORT : TICKS + LONG;
        return TICKS;
    endfunction

    initial begin
        int         sec_i, min_i, cnt, ftcnt;
        logic       ft_prev;
        logic [5:0] cal_m;
        logic [5:0] picks [6];
        string      tag;
        void'($urandom(32'h5EED));
        picks = '{6'h3F, 6'h1F, 6'h20, 6'h00, 6'h25, 6'h0A};
        rst = 1; stop = 0; osc_tick = 0; cal_in = 6'h23;
        sec_i = 0; min_i = 0; cnt = 0; ftcnt = 0; ft_prev = 0; cal_m = cal_in;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            if (rst) begin
                // R10 reset state
                check(sec_stb == 0 && min_stb == 0, "R10 strobes", {min_stb, sec_stb}, 0);
                check(ftest_out == 0, "R10 ftest", ftest_out, 0);
                sec_i = 0; min_i = 0; cnt = 0; ftcnt = 0; ft_prev = 0; cal_m = cal_in;
            end else begin
                if (stop) begin
                    check(sec_stb == 0, "R9 strobe while stopped", sec_stb, 0);
                    check(ftest_out == ft_prev, "R9 ftest frozen", ftest_out, ft_prev);
                end
                if (sec_stb) begin
                    int e;
                    e = exp_len(sec_i, min_i, cal_m);
                    if (cal_in != cal_m)                     tag = "R7 deferred cal";
                    else if (e < TICKS)                      tag = "R3 R4 short second";
                    else if (e > TICKS)                      tag = "R3 R5 long second";
                    else if (sec_i == 0 && cal_m[4:0] == 0)  tag = "R6 zero magnitude";
                    else                                     tag = "R1 nominal second";
                    check(cnt == e, tag, cnt, e);
                    check(min_stb == (sec_i == SECS - 1), "R2 minute marker", min_stb, sec_i == SECS - 1);
                    cnt = 0;
                    if (sec_i == SECS - 1) begin
                        sec_i = 0;
                        min_i = (min_i + 1) % MINS;
                        cal_m = cal_in;   // R7 sampled at minute boundary
                    end else begin
                        sec_i++;
                    end
                end else if (min_stb) begin
                    check(0, "R2 marker without strobe", 1, 0);
                end
                if (ftest_out != ft_prev) begin
                    check(ftcnt == TDIV/2, "R8 test toggle spacing", ftcnt, TDIV/2);
                    ftcnt = 0;
                    ft_prev = ftest_out;
                end
            end
            // Drive inputs for the next edge.
            rst = (cyc < 3) || (cyc >= RST2 && cyc < RST2 + 3);
            if (!stop) stop = ($urandom % 400) == 0;
            else       stop = ($urandom % 6) != 0;
            osc_tick = ($urandom % 8) != 0;
            if (($urandom % 1800) == 0) cal_in = picks[$urandom % 6];
            if (!rst && osc_tick && !stop) begin
                cnt++;
                ftcnt++;
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 195000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule